// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Divider

This block derives the bit timing of a serial port master from the peripheral clock. A first stage divides the clock by an even prescale value, between 2 and 254. A second stage divides that result again by one plus an 8-bit rate field. The serial bit rate is therefore f_in / (P × (1 + S)), where P is the even prescale value and S is the rate field. The fastest rate is f_in/2 and the slowest is f_in/(254 × 256).

The block produces two outputs. The first is a one-cycle strobe at every half bit period, which is (P/2) × (1 + S) input clocks. The second is a serial clock that toggles on each strobe and rests at a selectable idle level whenever no frame is running.

The counters are cleared while the port is disabled or no frame is active. A start pulse clears them again, so every frame begins with the same phase. The prescale and rate values arrive as plain inputs. Holding them in registers and shifting data are done by neighbouring logic.

Top module: `bitclk_divider`

## Requirements
- R1: With port_en and frame_act high, the first half_tick rises N = (P/2)×(1+S) clock edges after the edge that samples start, and later strobes follow every N edges. P is prescale_val with bit 0 cleared, and S is rate_val.
- R2: Bit 0 of prescale_val has no effect. A value of 5 gives the same timing as 4.
- R3: A prescale_val of 0 or 1 is treated as P = 2.
- R4: With P = 2 and S = 0, half_tick is high on every cycle and sclk inverts on every cycle, which is a bit rate of f_in/2.
- R5: With prescale_val = 254 and rate_val = 255, the strobe spacing is 32512 cycles, which is the slowest rate.
- R6: sclk inverts exactly on the edges where half_tick rises or stays high. When port_en or frame_act is low, sclk equals idle_pol one edge later.
- R7: No half_tick is produced while port_en or frame_act is low.
- R8: A start pulse in the middle of a frame returns sclk to idle_pol and restarts the count, so that the next strobe comes N edges after the start edge, whatever the earlier phase was.
- R9: Under synchronous reset, half_tick is 0 and sclk equals idle_pol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; when low, the counters are held cleared |
| frame_act | input | 1 | High while a frame is in progress |
| start | input | 1 | One-cycle pulse that aligns the phase at the start of a frame |
| prescale_val | input | 8 | First-stage divisor; bit 0 is ignored and 0 is treated as 2 |
| rate_val | input | 8 | Second-stage rate field S; the second stage divides by 1+S |
| idle_pol | input | 1 | Level of sclk when no frame is running |
| half_tick | output | 1 | One-cycle strobe at each half bit period |
| sclk | output | 1 | Serial clock |

## Verification
The hardest condition to create is a restart that arrives while both counters are part-way through a count, with sclk already away from its idle level. The bench reaches it by issuing a start, letting one strobe pass so that sclk has toggled, and then issuing a second start several cycles into the next period. It then checks that sclk returns to idle_pol at once and that the next strobe lands a full N cycles later. The slowest setting is also run to its end, so that the wrap of both counter widths is exercised.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  localparam int PRE_W_DEF  = 8;
  localparam int RATE_W_DEF = 8;
endpackage

// File: rtl/bitclk_prescale.sv
module bitclk_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [PRE_W-1:0] pre_val,
  output logic             pre_tick
);
  localparam int HALF_W = PRE_W - 1;

  logic [HALF_W-1:0] half_div;
  logic [HALF_W-1:0] cnt;

  // even coercion: drop bit 0, then halve; zero maps to the minimum of 1
  always_comb begin
    if (pre_val[PRE_W-1:1] == '0) half_div = HALF_W'(1);
    else                          half_div = pre_val[PRE_W-1:1];
  end

  assign pre_tick = !clear && (cnt >= half_div - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (pre_tick) cnt <= '0;
    else               cnt <= cnt + HALF_W'(1);
  end
endmodule

// File: rtl/bitclk_rate.sv
module bitclk_rate #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              pre_tick,
  input  logic [RATE_W-1:0] rate_val,
  output logic              tick_next
);
  logic [RATE_W-1:0] cnt;

  assign tick_next = pre_tick && (cnt >= rate_val);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (pre_tick) begin
      if (tick_next) cnt <= '0;
      else           cnt <= cnt + RATE_W'(1);
    end
  end
endmodule

// File: rtl/bitclk_shaper.sv
module bitclk_shaper (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic start,
  input  logic idle_pol,
  input  logic tick_next,
  output logic half_tick,
  output logic sclk
);
  always_ff @(posedge clk) begin
    if (rst || !run || start) begin
      half_tick <= 1'b0;
      sclk      <= idle_pol;
    end else begin
      half_tick <= tick_next;
      if (tick_next) sclk <= ~sclk;
    end
  end

  // R7: nothing is emitted while the port is idle
  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !run |=> !half_tick);

  // R6: idle level follows the polarity input
  a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sclk == $past(idle_pol)));

  // R6: every strobe coincides with a clock inversion
  a_r6_toggle_on_tick: assert property (@(posedge clk) disable iff (rst)
    half_tick |-> (sclk != $past(sclk)));

  // R8: start realigns to idle with no strobe
  a_r8_start_realign: assert property (@(posedge clk) disable iff (rst)
    (run && start) |=> (!half_tick && (sclk == $past(idle_pol))));
endmodule

// File: rtl/bitclk_divider.sv
module bitclk_divider
  import bitclk_pkg::*;
#(
  parameter int PRE_W  = PRE_W_DEF,
  parameter int RATE_W = RATE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              frame_act,
  input  logic              start,
  input  logic [PRE_W-1:0]  prescale_val,
  input  logic [RATE_W-1:0] rate_val,
  input  logic              idle_pol,
  output logic              half_tick,
  output logic              sclk
);
  logic run;
  logic clear;
  logic pre_tick;
  logic tick_next;

  assign run   = port_en && frame_act;
  assign clear = !run || start;

  bitclk_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .pre_val  (prescale_val),
    .pre_tick (pre_tick)
  );

  bitclk_rate #(.RATE_W(RATE_W)) u_rate (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .pre_tick  (pre_tick),
    .rate_val  (rate_val),
    .tick_next (tick_next)
  );

  bitclk_shaper u_shape (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .start     (start),
    .idle_pol  (idle_pol),
    .tick_next (tick_next),
    .half_tick (half_tick),
    .sclk      (sclk)
  );
endmodule

// File: tb/tb_bitclk_divider.sv
module tb_bitclk_divider;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_en = 1'b0;
  logic       frame_act = 1'b0;
  logic       start = 1'b0;
  logic [7:0] prescale_val = 8'd2;
  logic [7:0] rate_val = 8'd0;
  logic       idle_pol = 1'b0;
  logic       half_tick;
  logic       sclk;

  int n_cmp = 0;
  int n_err = 0;

  bitclk_divider dut (
    .clk(clk), .rst(rst), .port_en(port_en), .frame_act(frame_act),
    .start(start), .prescale_val(prescale_val), .rate_val(rate_val),
    .idle_pol(idle_pol), .half_tick(half_tick), .sclk(sclk)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic kick();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_strobe(output int k, input int lim);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!half_tick && k < lim);
    if (!half_tick) k = -1;
  endtask

  task automatic run_rate(input int p, input int s, input logic pol,
                          input int exp, input string tag);
    int k;
    @(negedge clk);
    prescale_val = 8'(p); rate_val = 8'(s); idle_pol = pol;
    port_en = 1'b1; frame_act = 1'b1;
    kick();
    chk({tag, " sclk idle after start"}, int'(sclk), int'(pol));
    wait_strobe(k, exp + 10);
    chk({tag, " first strobe delay"}, k, exp);
    chk({tag, " sclk after first strobe"}, int'(sclk), int'(!pol));
    wait_strobe(k, exp + 10);
    chk({tag, " strobe spacing"}, k, exp);
    chk({tag, " sclk after second strobe"}, int'(sclk), int'(pol));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R9 half_tick in reset", int'(half_tick), 0);
    chk("R9 sclk in reset", int'(sclk), 0);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_fastest();
    run_rate(2, 0, 1'b0, 1, "R4");
    for (int i = 0; i < 4; i++) begin
      logic prev;
      prev = sclk;
      @(negedge clk);
      chk("R4 strobe every cycle", int'(half_tick), 1);
      chk("R6 sclk inverts each cycle", int'(sclk), int'(!prev));
    end
  endtask

  task automatic t_quiet();
    int hits;
    @(negedge clk);
    prescale_val = 8'd4; rate_val = 8'd0; idle_pol = 1'b1;
    frame_act = 1'b0; port_en = 1'b1;
    hits = 0;
    repeat (2) @(negedge clk);
    chk("R6 idle level frame off", int'(sclk), 1);
    repeat (40) begin
      @(negedge clk);
      if (half_tick) hits++;
    end
    chk("R7 no strobes frame off", hits, 0);
    frame_act = 1'b1; port_en = 1'b0;
    hits = 0;
    repeat (40) begin
      @(negedge clk);
      if (half_tick) hits++;
    end
    chk("R7 no strobes port disabled", hits, 0);
    chk("R6 idle level port disabled", int'(sclk), 1);
  endtask

  task automatic t_restart();
    int k;
    @(negedge clk);
    prescale_val = 8'd8; rate_val = 8'd3; idle_pol = 1'b0;
    port_en = 1'b1; frame_act = 1'b1;
    kick();
    repeat (20) @(negedge clk);
    chk("R8 sclk toggled before restart", int'(sclk), 1);
    kick();
    chk("R8 sclk back to idle at restart", int'(sclk), 0);
    wait_strobe(k, 40);
    chk("R8 strobe realigned", k, 16);
  endtask

  initial begin
    #(PERIOD * 190000);
    n_cmp++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    t_reset();
    run_rate(6, 2, 1'b0, 9, "R1 p6 s2");
    run_rate(4, 0, 1'b1, 2, "R1 p4 s0");
    run_rate(10, 4, 1'b0, 25, "R1 p10 s4");
    run_rate(5, 1, 1'b0, 4, "R2 odd prescale");
    run_rate(0, 3, 1'b1, 4, "R3 prescale zero");
    run_rate(1, 3, 1'b0, 4, "R3 prescale one");
    t_fastest();
    t_quiet();
    t_restart();
    run_rate(254, 255, 1'b0, 32512, "R5 slowest");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule